// File: doc/BRIEF.md
# One-Shot Tick Countdown Timer

This block is a single-register countdown timer for a USB on-the-go controller. Software writes one 32-bit word. The top bit of that word arms the timer. The low 27 bits give a delay measured in cycles of the device clock. Once the timer is armed, it counts down the programmed number of ticks. It then emits a one-cycle timeout pulse toward the interrupt block and clears its register to zero. The interrupt block latches the pulse as a timeout source.

Reading the register returns the word as it was last written. It does not return the remaining count. The register changes on its own only at expiry, when it drops to zero. A write with the arm bit clear stores the word and disarms any countdown in progress. A write with the arm bit set discards any earlier countdown and starts again from the new count. There is no scaling to real time: the count is in raw clock ticks.

Top module: `oneshot_tick_timer`

## Requirements
- R1: After reset the register reads 0, the timeout output is low, and no timeout occurs until an armed write is made.
- R2: A write of any 32-bit word is visible in full on the read port in the cycle after the write edge, including bits 30:27.
- R3: A write with bit 31 set and count N in bits 26:0 makes the timeout output high in the cycle after the (N+1)th rising edge that follows the write edge. Bits 30:27 do not change this timing.
- R4: The timeout output is high for exactly one cycle for each expiry.
- R5: At expiry the register is cleared, so it reads 0 in the cycle in which the timeout output is high.
- R6: A write with bit 31 clear stores the word, cancels any pending countdown, and produces no timeout.
- R7: An armed write made while a countdown is running discards that countdown and restarts the timing of R3 from the new count.
- R8: An armed write with count 0 gives the timeout in the cycle after the next rising edge.
- R9: A write that lands on the edge where a countdown would expire takes precedence. No timeout comes from the old countdown, and the register holds the new word.
- R10: While a countdown runs, the read port keeps showing the written word rather than the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; the count is in its ticks |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, sampled on the rising edge |
| wrData | input | 32 | Write word: bit 31 arms, bits 26:0 hold the count |
| rdData | output | 32 | Value last written, or 0 after expiry |
| timeoutPulse | output | 1 | One-cycle timeout request |

## Verification
Call the edge that captures a write E. The read value changes one edge after E. The timeout pulse and the register clear appear together at edge E+N+1, so both are seen in the same cycle. The bench drives inputs on the falling edge and samples on the falling edge. It counts falling edges from the one right after the write and checks the pulse at exactly count N+1. At that same point it checks that the register reads zero, and on the following falling edge it checks that the pulse has gone low. For cancellation, the bench watches a window longer than the cancelled count and expects no pulse in it. For the collision case, the second write is placed so that it is captured on the old expiry edge.

// File: rtl/oneshot_timer_pkg.sv
package oneshot_timer_pkg;

  // Strobes from control to datapath, one set per clock.
  typedef struct packed {
    logic store;   // capture the written word
    logic load;    // reload the down-counter
    logic dec;     // count down one tick
    logic expire;  // countdown finished: clear word, fire pulse
  } tmrStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tmrState_t;

endpackage

// File: rtl/oneshot_timer_ctrl.sv
module oneshot_timer_ctrl
  import oneshot_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        armBit,
  input  logic        cntZero,
  output tmrStrobes_t strobe
);

  tmrState_t state, stateNext;

  always_comb begin
    strobe = '0;
    stateNext = state;
    if (wrEn) begin
      // A write always wins over a coincident expiry.
      strobe.store = 1'b1;
      strobe.load = armBit;
      stateNext = armBit ? ST_RUN : ST_IDLE;
    end else if (state == ST_RUN) begin
      if (cntZero) begin
        strobe.expire = 1'b1;
        stateNext = ST_IDLE;
      end else begin
        strobe.dec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

endmodule

// File: rtl/oneshot_timer_dp.sv
module oneshot_timer_dp
  import oneshot_timer_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] wrData,
  input  tmrStrobes_t      strobe,
  output logic             cntZero,
  output logic [REG_W-1:0] rdData,
  output logic             timeoutPulse
);

  logic [REG_W-1:0] regWord;
  logic [CNT_W-1:0] tickCnt;
  logic             pulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWord <= '0;
    end else if (strobe.store) begin
      regWord <= wrData;
    end else if (strobe.expire) begin
      regWord <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.load) begin
      tickCnt <= wrData[CNT_W-1:0];
    end else if (strobe.dec) begin
      tickCnt <= tickCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseQ <= 1'b0;
    else pulseQ <= strobe.expire;
  end

  assign cntZero = (tickCnt == '0);
  assign rdData = regWord;
  assign timeoutPulse = pulseQ;

endmodule

// File: rtl/oneshot_tick_timer.sv
module oneshot_tick_timer
  import oneshot_timer_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int CNT_W  = 27,
  parameter int EN_POS = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             timeoutPulse
);

  tmrStrobes_t strobe;
  logic        cntZero;

  oneshot_timer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .armBit  (wrData[EN_POS]),
    .cntZero (cntZero),
    .strobe  (strobe)
  );

  oneshot_timer_dp #(
    .REG_W (REG_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .wrData       (wrData),
    .strobe       (strobe),
    .cntZero      (cntZero),
    .rdData       (rdData),
    .timeoutPulse (timeoutPulse)
  );

endmodule

// File: rtl/oneshot_tick_timer_chk.sv
module oneshot_tick_timer_chk #(
  parameter int REG_W  = 32,
  parameter int CNT_W  = 27,
  parameter int EN_POS = 31
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic             timeoutPulse
);

  // R1: the register holds zero while reset is applied
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> rdData == '0);

  // R2: the written word appears on the read port one edge later
  p_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == $past(wrData));

  // R4: the pulse never lasts two cycles
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  // R5: the register reads zero while the pulse is high
  p_clear_on_expiry_r5: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> rdData == '0);

  // R6: a disarming write is not followed by a pulse
  p_disarm_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[EN_POS]) |=> !timeoutPulse);

  // R8: an armed zero count expires after the very next edge
  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[EN_POS] && wrData[CNT_W-1:0] == '0) ##1 !wrEn
      |=> timeoutPulse);

endmodule

bind oneshot_tick_timer oneshot_tick_timer_chk #(
  .REG_W  (REG_W),
  .CNT_W  (CNT_W),
  .EN_POS (EN_POS)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .rdData       (rdData),
  .timeoutPulse (timeoutPulse)
);

// File: tb/oneshot_tick_timer_bench.sv
module oneshot_tick_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 32;
  localparam int WATCHDOG_CYCLES = 20000;
  localparam int NUM_VEC = 6;

  // Stimulus word and expected falling edges to the pulse (-1: none).
  localparam logic [31:0] VEC_WORD [NUM_VEC] = '{
    32'h8000_0000, 32'h8000_0001, 32'h8000_0005,
    32'hF800_0003, 32'h8000_0040, 32'h0000_0007
  };
  localparam int VEC_DELAY [NUM_VEC] = '{1, 2, 6, 4, 65, -1};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [REG_W-1:0] wrData = '0;
  logic [REG_W-1:0] rdData;
  logic             timeoutPulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_tick_timer u_oneshot_tick_timer (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrData       (wrData),
    .rdData       (rdData),
    .timeoutPulse (timeoutPulse)
  );

  task automatic check(input bit ok, input string req,
                       input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  // Drive a write on a falling edge; returns at the falling edge after capture.
  task automatic doWrite(input logic [31:0] word);
    wrEn = 1'b1;
    wrData = word;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  // Count falling edges (from 0 = now) until the pulse shows; -1 if none.
  task automatic waitPulse(input int limit, output int found);
    found = -1;
    for (int k = 0; k <= limit; k++) begin
      if (timeoutPulse) begin
        found = k;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0x%0h expected=0x%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int got;
    // Reset state, R1
    repeat (3) @(negedge clk);
    check(rdData == '0, "R1 reset value", rdData, 0);
    check(timeoutPulse == 1'b0, "R1 pulse idle", timeoutPulse, 0);
    rstN = 1'b1;
    @(negedge clk);
    waitPulse(20, got);
    check(got == -1, "R1 no spontaneous timeout", got, -1);

    // Vector walk: R2, R3, R4, R5, R6, R8
    for (int i = 0; i < NUM_VEC; i++) begin
      doWrite(VEC_WORD[i]);
      check(rdData == VEC_WORD[i], "R2 readback", rdData, VEC_WORD[i]);
      waitPulse(VEC_DELAY[i] < 0 ? 40 : VEC_DELAY[i] + 5, got);
      if (VEC_WORD[i] == 32'h8000_0000)
        check(got == VEC_DELAY[i], "R8 zero count", got, VEC_DELAY[i]);
      else if (VEC_DELAY[i] < 0)
        check(got == -1, "R6 disarmed word no pulse", got, -1);
      else
        check(got == VEC_DELAY[i], "R3 expiry timing", got, VEC_DELAY[i]);
      if (got >= 0) begin
        check(rdData == '0, "R5 cleared at expiry", rdData, 0);
        @(negedge clk);
        check(timeoutPulse == 1'b0, "R4 one-cycle pulse", timeoutPulse, 0);
      end else begin
        check(rdData == VEC_WORD[i], "R6 word kept", rdData, VEC_WORD[i]);
      end
      repeat (2) @(negedge clk);
    end

    // R10: read port keeps the written word mid-count
    doWrite(32'h8000_0030);
    repeat (20) @(negedge clk);
    check(rdData == 32'h8000_0030, "R10 stable readback", rdData, 32'h8000_0030);
    waitPulse(60, got);
    check(got == 29, "R3 long count remainder", got, 29);
    repeat (2) @(negedge clk);

    // R6: cancel a running countdown
    doWrite(32'h8000_000A);
    repeat (3) @(negedge clk);
    doWrite(32'h0000_000A);
    waitPulse(30, got);
    check(got == -1, "R6 cancel", got, -1);
    check(rdData == 32'h0000_000A, "R6 stored word", rdData, 32'h0000_000A);

    // R7: restart while running
    doWrite(32'h8000_0014);
    repeat (5) @(negedge clk);
    doWrite(32'h8000_0004);
    waitPulse(40, got);
    check(got == 5, "R7 restart timing", got, 5);
    repeat (2) @(negedge clk);

    // R9: write on the old expiry edge wins
    doWrite(32'h8000_0003);
    repeat (3) @(negedge clk);
    doWrite(32'h8000_0006);
    check(timeoutPulse == 1'b0, "R9 old expiry suppressed", timeoutPulse, 0);
    check(rdData == 32'h8000_0006, "R9 new word held", rdData, 32'h8000_0006);
    waitPulse(20, got);
    check(got == 7, "R9 new countdown timing", got, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule